// File: doc/BRIEF.md
# Selectable mu-law / A-law companding unit

This block converts samples between the 16-bit linear words a host reads and writes and the 8-bit words a serial link carries. The transmit direction compresses a 16-bit two's-complement sample into an 8-bit mu-law or A-law code. The receive direction expands an 8-bit code into a 16-bit linear sample. Each direction can also pass data through unchanged. Each direction has its own 2-bit law selector, so one direction can compand while the other passes data through.

Each direction is a single register stage with valid/ready handshakes on its input and its output. The law selector is sampled in the cycle a word is accepted. Serialisation, bit clocks and framing belong to the surrounding port.

Top module: `compand_unit`

## Requirements
- R1: While reset (`rstN` low) is asserted, and in the first cycle after it is released, `txOutValid` and `rxOutValid` are low.
- R2: Each selector is decoded as follows: 2'b00 is pass-through, 2'b10 is mu-law and 2'b11 is A-law. The unused value 2'b01 behaves exactly like pass-through.
- R3: In transmit pass-through, the output code equals bits [7:0] of the accepted input word.
- R4: In receive pass-through, the output word is the 8-bit input code zero-extended to 16 bits.
- R5: For mu-law compression, v = input >>> 2 (14-bit signed) and mag = |v|, clipped to 8158. Then b = mag + 33, seg is the position of the highest set bit of b minus 5, and mant = (b >> (seg+1)) & 15. The output code is the bitwise inverse of {neg, seg[2:0], mant[3:0]}, where neg is 1 for a negative v.
- R6: For mu-law expansion, u = ~code, s = u[6:4] and m = u[3:0]. The output is (((2m+33) << s) − 33) × 4. It is negated when u[7] is 1. As a result, its two low bits are zero and its magnitude is at most 32124.
- R7: For A-law compression, v = input >>> 3 (13-bit signed), and mag = v for v ≥ 0 or −v−1 for v < 0. seg is 0 when mag < 32, and otherwise the position of the highest set bit of mag minus 4. mant = (mag >> max(seg,1)) & 15. The output code is {v ≥ 0, seg, mant} XOR 8'h55.
- R8: For A-law expansion, a = code XOR 8'h55, s = a[6:4] and m = a[3:0]. The magnitude is 2m+1 when s = 0, and (2m+33) << (s−1) otherwise. The output is that magnitude × 8. It is positive when a[7] is 1 and negative otherwise, so its three low bits are zero.
- R9: The two selectors act independently, so both directions can carry words under different laws in the same cycles.
- R10: An input is accepted when its valid and ready signals are both high. Ready equals (output valid low) or (output ready high). An accepted word appears on the output, with output valid high, in the next cycle. Output valid falls after a transfer that has no new accept.
- R11: While output valid is high and output ready is low, the output valid and output data stay unchanged.
- R12: Compression saturates and never wraps. Positive samples beyond the largest code give 8'h80 in mu-law and 8'hAA in A-law. Negative samples give 8'h00 in mu-law and 8'h2A in A-law. This includes 16'h8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txMode | input | 2 | Transmit law selector |
| txInValid | input | 1 | Host sample offered |
| txInReady | output | 1 | Transmit stage can take a sample |
| txInData | input | 16 | Linear host sample |
| txOutValid | output | 1 | Compressed code available |
| txOutReady | input | 1 | Link side takes the code |
| txOutData | output | 8 | Compressed wire code |
| rxMode | input | 2 | Receive law selector |
| rxInValid | input | 1 | Wire code offered |
| rxInReady | output | 1 | Receive stage can take a code |
| rxInData | input | 8 | Received wire code |
| rxOutValid | output | 1 | Expanded sample available |
| rxOutReady | input | 1 | Host side takes the sample |
| rxOutData | output | 16 | Expanded linear sample |

## Verification
The assertions check four things on every cycle. A stalled output must hold its valid flag and data. An accepted word must raise output valid. Every expansion result must have the zero low bits and the range that its law implies, and a pass-through receive word must have a zero upper byte. A full-scale negative sample must compress to the saturated mu-law code. The exact code for each sample, the exact linear value for each of the 256 codes under each law, the decoding of the unused selector value, and the two directions running under different laws at once can only be shown by the bench scenarios. These scenarios compare every cycle against a behavioural model under random valid and ready patterns.

// File: rtl/compand_pkg.sv
package compand_pkg;
  localparam int HOST_W  = 16;
  localparam int WIRE_W  = 8;
  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;

  localparam logic [13:0] MU_CLIP = 14'd8158;
  localparam logic [12:0] MU_BIAS = 13'd33;
  localparam logic [7:0]  A_FLIP  = 8'h55;

  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_MU   = 2'b10,
    MODE_A    = 2'b11
  } law_e;

  typedef struct packed {
    logic txLoad;
    logic rxLoad;
  } strobe_t;
endpackage

// File: rtl/compand_ctrl.sv
module compand_ctrl
  import compand_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DIR-1:0] inValid,
  output logic [NUM_DIR-1:0] inReady,
  output logic [NUM_DIR-1:0] outValid,
  input  logic [NUM_DIR-1:0] outReady,
  output strobe_t            strobe
);
  logic [NUM_DIR-1:0] load;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic validQ;

    assign inReady[d]  = !validQ || outReady[d];
    assign load[d]     = inValid[d] && inReady[d];
    assign outValid[d] = validQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            validQ <= 1'b0;
      else if (load[d])     validQ <= 1'b1;
      else if (outReady[d]) validQ <= 1'b0;
    end

    // R10: an accepted word is presented in the following cycle
    a_r10_fill: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[d] && inReady[d]) |=> outValid[d]);
  end

  assign strobe.txLoad = load[DIR_TX];
  assign strobe.rxLoad = load[DIR_RX];
endmodule

// File: rtl/compand_dp.sv
module compand_dp
  import compand_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [1:0]        txMode,
  input  logic [HOST_W-1:0] txIn,
  output logic [WIRE_W-1:0] txOut,
  input  logic [1:0]        rxMode,
  input  logic [WIRE_W-1:0] rxIn,
  output logic [HOST_W-1:0] rxOut
);
  function automatic logic [7:0] muEncode(input logic [15:0] s);
    logic [13:0] v, mag;
    logic [12:0] biased;
    logic [2:0]  seg;
    logic [3:0]  mant;
    logic        neg;
    v   = s[15:2];
    neg = v[13];
    mag = neg ? (~v + 14'd1) : v;
    if (mag > MU_CLIP) mag = MU_CLIP;
    biased = mag[12:0] + MU_BIAS;
    seg = 3'd0;
    for (int i = 0; i < 8; i++) if (biased[5+i]) seg = 3'(i);
    mant = 4'(biased >> ({1'b0, seg} + 4'd1));
    return ~{neg, seg, mant};
  endfunction

  function automatic logic [7:0] aEncode(input logic [15:0] s);
    logic [12:0] v;
    logic [11:0] mag;
    logic [2:0]  seg, sh;
    logic [3:0]  mant;
    logic        neg;
    v   = s[15:3];
    neg = v[12];
    mag = neg ? ~v[11:0] : v[11:0];
    seg = 3'd0;
    for (int i = 0; i < 7; i++) if (mag[5+i]) seg = 3'(i + 1);
    sh   = (seg == 3'd0) ? 3'd1 : seg;
    mant = 4'(mag >> sh);
    return {~neg, seg, mant} ^ A_FLIP;
  endfunction

  function automatic logic [15:0] muDecode(input logic [7:0] c);
    logic [7:0]  u;
    logic [15:0] t, mag;
    u   = ~c;
    t   = ({9'd0, u[3:0], 3'b000} + 16'd132) << u[6:4];
    mag = t - 16'd132;
    return u[7] ? (~mag + 16'd1) : mag;
  endfunction

  function automatic logic [15:0] aDecode(input logic [7:0] c);
    logic [7:0]  a;
    logic [15:0] base, t;
    a    = c ^ A_FLIP;
    base = {8'h00, a[3:0], 4'h0};
    if (a[6:4] == 3'd0) t = base + 16'd8;
    else                t = (base + 16'h0108) << (a[6:4] - 3'd1);
    return a[7] ? t : (~t + 16'd1);
  endfunction

  logic [WIRE_W-1:0] txNext, txOutQ;
  logic [HOST_W-1:0] rxNext, rxOutQ;

  always_comb begin
    case (law_e'(txMode))
      MODE_MU: txNext = muEncode(txIn);
      MODE_A:  txNext = aEncode(txIn);
      default: txNext = txIn[WIRE_W-1:0];
    endcase
  end

  always_comb begin
    case (law_e'(rxMode))
      MODE_MU: rxNext = muDecode(rxIn);
      MODE_A:  rxNext = aDecode(rxIn);
      default: rxNext = {{(HOST_W-WIRE_W){1'b0}}, rxIn};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txOutQ <= '0;
    else if (strobe.txLoad) txOutQ <= txNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxOutQ <= '0;
    else if (strobe.rxLoad) rxOutQ <= rxNext;
  end

  assign txOut = txOutQ;
  assign rxOut = rxOutQ;

  // R6: mu-law expansion lands on a multiple of 4 within +/-32124
  a_r6_mu_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxLoad && rxMode == MODE_MU) |=>
      (rxOutQ[1:0] == 2'b00 && $signed(rxOutQ) <= 32124 && $signed(rxOutQ) >= -32124));

  // R8: A-law expansion lands on a multiple of 8
  a_r8_a_align: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxLoad && rxMode == MODE_A) |=> (rxOutQ[2:0] == 3'b000));

  // R4: pass-through receive leaves the upper byte clear
  a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxLoad && (rxMode == MODE_PASS || rxMode == MODE_RSVD)) |=> (rxOutQ[15:8] == 8'h00));

  // R12: the most negative sample saturates to the largest negative mu-law code
  a_r12_mu_sat: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txLoad && txMode == MODE_MU && txIn == 16'h8000) |=> (txOutQ == 8'h00));
endmodule

// File: rtl/compand_unit.sv
module compand_unit
  import compand_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  txMode,
  input  logic        txInValid,
  output logic        txInReady,
  input  logic [15:0] txInData,
  output logic        txOutValid,
  input  logic        txOutReady,
  output logic [7:0]  txOutData,
  input  logic [1:0]  rxMode,
  input  logic        rxInValid,
  output logic        rxInReady,
  input  logic [7:0]  rxInData,
  output logic        rxOutValid,
  input  logic        rxOutReady,
  output logic [15:0] rxOutData
);
  strobe_t            strobe;
  logic [NUM_DIR-1:0] inValid, inReady, outValid, outReady;

  assign inValid[DIR_TX]  = txInValid;
  assign inValid[DIR_RX]  = rxInValid;
  assign outReady[DIR_TX] = txOutReady;
  assign outReady[DIR_RX] = rxOutReady;
  assign txInReady        = inReady[DIR_TX];
  assign rxInReady        = inReady[DIR_RX];
  assign txOutValid       = outValid[DIR_TX];
  assign rxOutValid       = outValid[DIR_RX];

  compand_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  compand_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .txMode (txMode),
    .txIn   (txInData),
    .txOut  (txOutData),
    .rxMode (rxMode),
    .rxIn   (rxInData),
    .rxOut  (rxOutData)
  );

  // R11: stalled outputs hold
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txOutValid && !txOutReady) |=> (txOutValid && $stable(txOutData)));

  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxOutValid && !rxOutReady) |=> (rxOutValid && $stable(rxOutData)));
endmodule

// File: tb/compand_unit_test.sv
module compand_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  txMode = 2'b00, rxMode = 2'b00;
  logic        txInValid = 1'b0, txOutReady = 1'b0, rxInValid = 1'b0, rxOutReady = 1'b0;
  logic [15:0] txInData = '0;
  logic [7:0]  rxInData = '0;
  logic        txInReady, txOutValid, rxInReady, rxOutValid;
  logic [7:0]  txOutData;
  logic [15:0] rxOutData;

  always #4 clk = ~clk;

  compand_unit uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] txQ[$];
  logic [1:0]  txMQ[$];
  string       txTQ[$];
  logic [7:0]  rxQ[$];
  logic [1:0]  rxMQ[$];
  string       rxTQ[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int refMuEnc(input logic [15:0] s);
    int v, mag, seg, mant;
    bit neg;
    v = $signed(s) >>> 2;
    neg = (v < 0);
    mag = neg ? -v : v;
    if (mag > 8158) mag = 8158;
    mag = mag + 33;
    seg = 0;
    while ((mag >> (seg + 6)) != 0) seg++;
    mant = (mag >> (seg + 1)) & 15;
    return ((neg ? 128 : 0) | (seg << 4) | mant) ^ 255;
  endfunction

  function automatic int refAEnc(input logic [15:0] s);
    int v, mag, seg, mant;
    bit neg;
    v = $signed(s) >>> 3;
    neg = (v < 0);
    mag = neg ? (-v - 1) : v;
    seg = 0;
    while (seg < 7 && mag >= (32 << seg)) seg++;
    mant = (seg < 2) ? ((mag >> 1) & 15) : ((mag >> seg) & 15);
    return ((neg ? 0 : 128) | (seg << 4) | mant) ^ 8'h55;
  endfunction

  function automatic int refMuDec(input logic [7:0] c);
    int u, mag;
    u = c ^ 255;
    mag = (((2 * (u & 15) + 33) << ((u >> 4) & 7)) - 33) * 4;
    return ((u & 128) != 0) ? -mag : mag;
  endfunction

  function automatic int refADec(input logic [7:0] c);
    int a, s, m, mag;
    a = c ^ 8'h55;
    s = (a >> 4) & 7;
    m = a & 15;
    mag = (s == 0) ? (2 * m + 1) : ((2 * m + 33) << (s - 1));
    mag = mag * 8;
    return ((a & 128) != 0) ? mag : -mag;
  endfunction

  function automatic int refTx(input logic [15:0] s, input logic [1:0] m);
    case (m)
      2'b10:   return refMuEnc(s);
      2'b11:   return refAEnc(s);
      default: return int'(s[7:0]);
    endcase
  endfunction

  function automatic int refRx(input logic [7:0] c, input logic [1:0] m);
    case (m)
      2'b10:   return refMuDec(c) & 32'hFFFF;
      2'b11:   return refADec(c) & 32'hFFFF;
      default: return int'(c);
    endcase
  endfunction

  task automatic addTx(input int s, input logic [1:0] m, input string tag);
    txQ.push_back(16'(s)); txMQ.push_back(m); txTQ.push_back(tag);
  endtask

  task automatic addRx(input int c, input logic [1:0] m, input string tag);
    rxQ.push_back(8'(c)); rxMQ.push_back(m); rxTQ.push_back(tag);
  endtask

  bit    txExpV = 0, rxExpV = 0, txStall = 0, rxStall = 0, txAcc, rxAcc;
  int    txExpD = 0, rxExpD = 0;
  string txExpT = "", rxExpT = "";

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk(txOutValid == 1'b0, "R1 tx valid in reset", txOutValid, 0);
    chk(rxOutValid == 1'b0, "R1 rx valid in reset", rxOutValid, 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(posedge clk); #2;
    chk(txOutValid == 1'b0, "R1 tx valid after reset", txOutValid, 0);
    chk(rxOutValid == 1'b0, "R1 rx valid after reset", rxOutValid, 0);

    // Phase 1: rx mu-law over all codes while tx passes through (R9)
    for (int i = 0; i < 256; i++) begin
      addRx(i, 2'b10, "R6");
      addTx(i * 251 - 32768, 2'b00, "R3 R9");
    end
    // Phase 2: rx A-law over all codes while tx compresses mu-law (R9)
    for (int i = 0; i < 256; i++) begin
      addRx(i, 2'b11, "R8 R9");
      addTx(i * 257 - 32768, 2'b10, "R5");
    end
    // Phase 3: rx pass-through over all codes while tx compresses A-law
    for (int i = 0; i < 256; i++) begin
      addRx(i, 2'b00, "R4");
      addTx(i * 257 - 32768 + 3, 2'b11, "R7");
    end
    // Phase 4: small magnitudes, saturation, unused selector value
    foreach (txQ[k]) begin end
    for (int i = -40; i <= 40; i += 5) begin
      addTx(i, 2'b10, "R5");
      addTx(i, 2'b11, "R7");
    end
    addTx(32767, 2'b10, "R12");  addTx(-32768, 2'b10, "R12");
    addTx(32700, 2'b10, "R12");  addTx(-32700, 2'b10, "R12");
    addTx(32767, 2'b11, "R12");  addTx(-32768, 2'b11, "R12");
    addTx(32760, 2'b11, "R12");  addTx(-32760, 2'b11, "R12");
    addTx(16'hA5C3, 2'b01, "R2"); addTx(16'h1234, 2'b01, "R2");
    addRx(8'hC3, 2'b01, "R2");    addRx(8'h80, 2'b01, "R2");

    while (txQ.size() > 0 || rxQ.size() > 0 || txExpV || rxExpV) begin
      txInValid  = (txQ.size() > 0) && ($urandom % 4 != 0);
      rxInValid  = (rxQ.size() > 0) && ($urandom % 4 != 0);
      if (txQ.size() > 0) begin txInData = txQ[0]; txMode = txMQ[0]; end
      if (rxQ.size() > 0) begin rxInData = rxQ[0]; rxMode = rxMQ[0]; end
      txOutReady = ($urandom % 3 != 0);
      rxOutReady = ($urandom % 3 != 0);
      #5;
      chk(txInReady == (!txExpV || txOutReady), "R10 tx ready", txInReady, !txExpV || txOutReady);
      chk(rxInReady == (!rxExpV || rxOutReady), "R10 rx ready", rxInReady, !rxExpV || rxOutReady);
      chk(txOutValid == txExpV, "R10 tx valid", txOutValid, txExpV);
      chk(rxOutValid == rxExpV, "R10 rx valid", rxOutValid, rxExpV);
      if (txExpV)
        chk(int'(txOutData) == txExpD, txStall ? {"R11 ", txExpT} : txExpT, txOutData, txExpD);
      if (rxExpV)
        chk(int'(rxOutData) == rxExpD, rxStall ? {"R11 ", rxExpT} : rxExpT, rxOutData, rxExpD);

      txAcc = txInValid && (!txExpV || txOutReady);
      rxAcc = rxInValid && (!rxExpV || rxOutReady);
      if (txAcc) begin
        txExpV = 1; txExpD = refTx(txQ[0], txMQ[0]); txExpT = txTQ[0]; txStall = 0;
        void'(txQ.pop_front()); void'(txMQ.pop_front()); void'(txTQ.pop_front());
      end else if (txOutReady) begin
        txExpV = 0; txStall = 0;
      end else txStall = txExpV;
      if (rxAcc) begin
        rxExpV = 1; rxExpD = refRx(rxQ[0], rxMQ[0]); rxExpT = rxTQ[0]; rxStall = 0;
        void'(rxQ.pop_front()); void'(rxMQ.pop_front()); void'(rxTQ.pop_front());
      end else if (rxOutReady) begin
        rxExpV = 0; rxStall = 0;
      end else rxStall = rxExpV;
      @(posedge clk); #1;
    end

    // R12: saturated codes pinned against fixed values
    chk(refMuEnc(16'h8000) == 8'h00 && refAEnc(16'h7FFF) == 8'hAA, "R12 model", 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule